// File: doc/BRIEF.md
# Group-Gray Coded Accumulator

This block keeps a running sum in a register and adds one input word to it on every cycle in which the enable strobe is high. The input bus, the adder output and the register all carry values in a group-Gray code. The word is cut into 2-bit digits. Each digit is Gray-coded on its own, and the carry between digits follows ordinary binary weighting. Counting sequences and other slowly changing streams therefore switch fewer bus wires than plain binary does.

The arithmetic core comes in two forms, chosen by a parameter. The default form is a plain binary adder with a ring of XOR converters: the XORs decode both operands before the adder and encode the sum after it. The other form adds the coded digits directly, one digit at a time, with a carry between digits. Either form can be built at 8 or 16 bits. A small registered counter reports how many register bits flipped on the most recent update. A bench can use it to measure the bus activity of a counting sequence.

Top module: `gcode_accum`

## Requirements
- R1: A synchronous active-high reset clears the accumulator output to all zeros, which is the code for zero, and clears the toggle count to zero. Both are visible after the next rising edge.
- R2: Code definition: the word is split into 2-bit digits, digit k at bits 2k+1..2k with weight 4^k. A digit of value v is stored as v XOR (v>>1), so 0,1,2,3 become 00,01,11,10. The data input uses this code, and so does the accumulator output.
- R3: On a rising edge with enable high, the accumulator takes the code of (decoded sum + decoded input).
- R4: On a rising edge with enable low, the accumulator holds its value and the toggle count becomes zero, whatever the data input carries.
- R5: The sum wraps modulo 2^WIDTH and any carry out of the top digit is dropped. For example, at 8 bits, 250 + 10 gives 4.
- R6: On each enabled update, the toggle count becomes the number of accumulator bits that differ between the old value and the new value. It is registered on the same edge as the accumulator.
- R7: The direct-digit adder (NATIVE=1) and the converter-wrapped binary adder (NATIVE=0) give the same accumulator and toggle values for every input sequence.
- R8: An 8-bit count from 0 up to 255 in steps of +1, then back to 0 in steps of -1 (input code of 255), gives a summed toggle count of 672. Plain binary counting over the same sweep flips 1004 bits.
- R9: WIDTH may be 8 or 16. At 16 bits the same code and wrap rules apply, modulo 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Add strobe |
| din | input | WIDTH | Group-Gray coded addend |
| acc | output | WIDTH | Group-Gray coded running sum |
| tgl | output | $clog2(WIDTH+1) | Bits flipped by the last update |

## Verification
Every result is due one rising edge after its stimulus. The accumulator, the toggle count and the effect of reset all come from a single register stage. The bench drives inputs on the falling edge and updates its binary reference model at the same moment. It compares the outputs on the next falling edge, which comes after the single edge that captures them, so each comparison matches exactly one stimulus. For the sweep total, the bench adds up the toggle count sampled in the same way, one sample per step.

// File: rtl/gcode_accum.sv
module gcode_accum #(
  parameter int WIDTH  = 8,
  parameter bit NATIVE = 1'b0,
  localparam int NDIG = WIDTH / 2,
  localparam int CW   = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] acc,
  output logic [CW-1:0]    tgl
);

  function automatic logic [WIDTH-1:0] to_bin(input logic [WIDTH-1:0] g);
    logic [WIDTH-1:0] b;
    for (int k = 0; k < NDIG; k++) begin
      b[2*k+1] = g[2*k+1];
      b[2*k]   = g[2*k+1] ^ g[2*k];
    end
    return b;
  endfunction

  function automatic logic [WIDTH-1:0] to_code(input logic [WIDTH-1:0] b);
    logic [WIDTH-1:0] g;
    for (int k = 0; k < NDIG; k++) begin
      g[2*k+1] = b[2*k+1];
      g[2*k]   = b[2*k+1] ^ b[2*k];
    end
    return g;
  endfunction

  function automatic logic [1:0] dig_val(input logic [1:0] g);
    case (g)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] dig_code(input logic [1:0] v);
    case (v)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      2'd2:    return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  logic [WIDTH-1:0] acc_q, sum_g, flip;
  logic [CW-1:0]    tgl_q, ones;

  generate
    if (NATIVE) begin : g_native
      always_comb begin
        logic       c;
        logic [2:0] s;
        c = 1'b0;
        for (int k = 0; k < NDIG; k++) begin
          s = {1'b0, dig_val(acc_q[2*k +: 2])} + {1'b0, dig_val(din[2*k +: 2])} + {2'b0, c};
          sum_g[2*k +: 2] = dig_code(s[1:0]);
          c = s[2];
        end
      end
    end else begin : g_conv
      logic [WIDTH-1:0] a_b, d_b, s_b;
      assign a_b   = to_bin(acc_q);
      assign d_b   = to_bin(din);
      assign s_b   = a_b + d_b;
      assign sum_g = to_code(s_b);
    end
  endgenerate

  assign flip = acc_q ^ sum_g;

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIDTH; i++) ones = ones + CW'(flip[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tgl_q <= '0;
    end else if (en) begin
      acc_q <= sum_g;
      tgl_q <= ones;
    end else begin
      tgl_q <= '0;
    end
  end

  assign acc = acc_q;
  assign tgl = tgl_q;

  function automatic logic [WIDTH-1:0] weigh(input logic [WIDTH-1:0] g);
    logic [WIDTH-1:0] v;
    v = '0;
    for (int k = NDIG - 1; k >= 0; k--) v = (v << 2) | WIDTH'(dig_val(g[2*k +: 2]));
    return v;
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (acc == '0 && tgl == '0)); // R1
  AST_ADD_STEP: assert property (@(posedge clk) disable iff (rst)
    en |=> weigh(acc) == WIDTH'(weigh($past(acc)) + weigh($past(din)))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(acc)); // R4
  AST_IDLE_NO_TGL: assert property (@(posedge clk) disable iff (rst) !en |=> tgl == '0); // R4
  AST_TGL_COUNT: assert property (@(posedge clk) disable iff (rst)
    en |=> tgl == CW'($countones($past(acc) ^ acc))); // R6

endmodule

// File: tb/sim_gcode_accum.sv
`timescale 1ns/1ps
module sim_gcode_accum;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [7:0]  din8 = '0;
  logic [15:0] din16 = '0;
  logic [7:0]  acc0, acc1;
  logic [15:0] acc2;
  logic [3:0]  tgl0, tgl1;
  logic [4:0]  tgl2;
  int checks = 0, fails = 0;
  int unsigned ref8 = 0, ref16 = 0;
  int r_tgl_sum = 0;

  always #4 clk = ~clk;

  gcode_accum #(.WIDTH(8),  .NATIVE(1'b0)) u0 (.clk(clk), .rst(rst), .en(en), .din(din8),  .acc(acc0), .tgl(tgl0));
  gcode_accum #(.WIDTH(8),  .NATIVE(1'b1)) u1 (.clk(clk), .rst(rst), .en(en), .din(din8),  .acc(acc1), .tgl(tgl1));
  gcode_accum #(.WIDTH(16), .NATIVE(1'b0)) u2 (.clk(clk), .rst(rst), .en(en), .din(din16), .acc(acc2), .tgl(tgl2));

  function automatic int unsigned enc(input int unsigned v, input int w);
    int unsigned g = 0;
    for (int k = 0; k < w / 2; k++) begin
      int unsigned d = (v >> (2 * k)) & 3;
      g = g | ((d ^ (d >> 1)) << (2 * k));
    end
    return g;
  endfunction

  function automatic int pop(input int unsigned x);
    int n = 0;
    for (int i = 0; i < 32; i++) n += (x >> i) & 1;
    return n;
  endfunction

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic step(input bit e, input int unsigned v8, input int unsigned v16);
    int unsigned o8 = ref8, o16 = ref16;
    int et8, et16;
    en = e;
    din8 = 8'(enc(v8, 8));
    din16 = 16'(enc(v16, 16));
    if (e) begin
      ref8 = (ref8 + v8) & 32'hFF;
      ref16 = (ref16 + v16) & 32'hFFFF;
    end
    et8 = e ? pop(enc(o8, 8) ^ enc(ref8, 8)) : 0;
    et16 = e ? pop(enc(o16, 16) ^ enc(ref16, 16)) : 0;
    @(negedge clk);
    chk(e ? "R3" : "R4", acc0, enc(ref8, 8));
    chk("R6", tgl0, et8);
    chk("R7", acc1, acc0);
    chk("R7", tgl1, tgl0);
    chk("R9", acc2, enc(ref16, 16));
    chk("R9", tgl2, et16);
    r_tgl_sum += tgl0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ref8 = 0;
    ref16 = 0;
    chk("R1", acc0, 0);
    chk("R1", tgl0, 0);
    chk("R1", acc2, 0);
    chk("R1", tgl2, 0);
  endtask

  initial begin
    #(8.0 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bin_sum;
    int hyb_exp;
    int s;
    @(negedge clk);
    do_reset();

    // R2: a single add of each digit value exposes the code
    step(1'b1, 2, 2);
    chk("R2", acc0, 8'b0000_0011);
    step(1'b1, 6, 6);
    chk("R2", acc0, 8'b0000_1100);

    // R4: idle cycles with busy input
    for (int i = 0; i < 20; i++) step(1'b0, $urandom & 8'hFF, $urandom & 16'hFFFF);

    // R5: wrap
    do_reset();
    step(1'b1, 250, 65530);
    step(1'b1, 10, 10);
    chk("R5", acc0, enc(4, 8));
    chk("R5", acc2, enc(4, 16));

    // R3/R7: every addend value against a moving sum
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 256; b++) step(1'b1, b, (b * 257 + a) & 16'hFFFF);

    // random stream with random enable
    for (int i = 0; i < 3000; i++) step(1'($urandom & 1), $urandom & 8'hFF, $urandom & 16'hFFFF);

    // correlated stream: small signed steps
    s = 0;
    for (int i = 0; i < 3000; i++) begin
      s = ((i / 40) % 2 == 0) ? (i % 4) : -(i % 4);
      step(1'b1, s & 8'hFF, s & 16'hFFFF);
    end

    // R8: count sweep
    do_reset();
    r_tgl_sum = 0;
    hyb_exp = 0;
    bin_sum = 0;
    for (int v = 0; v < 255; v++) begin
      hyb_exp += pop(enc(v, 8) ^ enc(v + 1, 8));
      bin_sum += pop(v ^ (v + 1));
      step(1'b1, 1, 1);
    end
    for (int v = 255; v > 0; v--) begin
      hyb_exp += pop(enc(v, 8) ^ enc(v - 1, 8));
      bin_sum += pop(v ^ (v - 1));
      step(1'b1, 255, 65535);
    end
    chk("R8", acc0, 0);
    chk("R8", r_tgl_sum, hyb_exp);
    chk("R8", r_tgl_sum, 672);
    chk("R8", bin_sum, 1004);

    do_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule